// File: doc/BRIEF.md
# Streaming Top-K Score Selector

The selector takes scored candidates from several parallel similarity lanes and keeps the K highest scores, each with the identifier of the item that produced it. A round-robin arbiter takes one candidate per clock cycle from the lanes and holds off every lane it does not grant. The granted candidate goes into a sorted insertion array of K register slots. A candidate that beats a slot pushes that slot and every slot below it down by one position. A candidate that beats no slot is dropped, and the array is left as it was. The time to process N items therefore grows as about N cycles.

A query begins with a one-cycle start pulse, which empties the array. The lanes then stream their candidates. A one-cycle end pulse stops intake and starts the readout. The readout emits one (score, identifier) pair per cycle, from the highest score to the lowest, and sets a last flag on the final retained entry. Scores are two's-complement signed values. The block keeps no history from one query to the next.

Top module: `topk_selector`

## Requirements
- R1: In every cycle where at least one lane is valid and neither start nor end is high and no readout is running, exactly one lane is granted (ready high), so the block accepts one candidate per cycle.
- R2: The grant rotates: the search starts at the lane after the one granted last and wraps around. If all lanes are held valid for 2*LANES cycles, each lane is granted exactly twice.
- R3: A lane's ready is high only when that lane's valid is high. Every ready is low in a cycle where start or end is high, and while a readout is still emitting entries.
- R4: After any stream, the retained list holds the min(n, K) highest scores of the n accepted candidates, each paired with its own identifier. A candidate that scores below every slot of a full array is discarded.
- R5: Equal scores keep their order of acceptance: the entry accepted earlier is read out first.
- R6: The first entry appears on the outputs in the second cycle after the cycle in which end is sampled high. Further entries follow one per cycle with no gaps, in non-increasing score order.
- R7: The readout emits exactly min(n, K) entries. The last flag is high only on the final entry. If no candidate was accepted, no entry is emitted.
- R8: A start pulse empties every slot and cancels any readout in progress. The output valid is low in the cycle after start.
- R9: After reset, the output valid, the last flag and every ready are low, and the array is empty.
- R10: The most negative score is still retained as a valid entry while a free slot exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Query start pulse; empties the slots |
| end_i | input | 1 | End-of-stream pulse; starts the readout |
| lane_valid_i | input | LANES | Per-lane candidate valid |
| lane_score_i | input | LANES*SCORE_W | Signed score per lane; lane j occupies bits [j*SCORE_W +: SCORE_W] |
| lane_id_i | input | LANES*ID_W | Item identifier per lane; lane j occupies bits [j*ID_W +: ID_W] |
| lane_ready_o | output | LANES | Per-lane grant; a candidate is taken on a clock edge where valid and ready are both high |
| out_valid_o | output | 1 | Readout entry valid |
| out_score_o | output | SCORE_W | Readout score |
| out_id_o | output | ID_W | Readout identifier |
| out_last_o | output | 1 | High on the final retained entry |

## Verification
The bench goes after three groups of cases. The first is ties. A design that compares with greater-or-equal would let a later equal score jump ahead of an earlier one, and the identifiers would come out swapped. The second is a stream of more than K candidates. A design with an off-by-one at the bottom slot would keep a score it should have dropped. The third is streams shorter than K or empty. A design that does not stop at the first empty slot would emit entries holding the most negative score, or would place the last flag wrongly. The bench also checks three more things. A start pulse given in the middle of a query must leave no stale entries. A candidate holding the most negative score must still be kept. No lane may be granted while the readout is running, because such a candidate would be lost.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic {RD_IDLE, RD_RUN} rd_state_e;
endpackage

// File: rtl/topk_rr_arbiter.sv
module topk_rr_arbiter #(
  parameter int LANES   = 16,
  parameter int SCORE_W = 16,
  parameter int ID_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      enable,
  input  logic [LANES-1:0]          valid_i,
  input  logic [LANES*SCORE_W-1:0]  score_i,
  input  logic [LANES*ID_W-1:0]     id_i,
  output logic [LANES-1:0]          grant_o,
  output logic                      cand_valid_o,
  output logic signed [SCORE_W-1:0] cand_score_o,
  output logic [ID_W-1:0]           cand_id_o
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [PW-1:0] ptr_q;
  logic          found;
  int            gidx;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    gidx    = 0;
    for (int k = 0; k < LANES; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= LANES) idx = idx - LANES;
      if (!found && enable && valid_i[idx]) begin
        grant_o[idx] = 1'b1;
        found        = 1'b1;
        gidx         = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cand_valid_o <= 1'b0;
      cand_score_o <= '0;
      cand_id_o    <= '0;
      if (rst) ptr_q <= '0;
    end else begin
      cand_valid_o <= found;
      if (found) begin
        cand_score_o <= score_i[gidx*SCORE_W +: SCORE_W];
        cand_id_o    <= id_i[gidx*ID_W +: ID_W];
        ptr_q        <= (gidx == LANES-1) ? '0 : PW'(gidx + 1);
      end
    end
  end
endmodule

// File: rtl/topk_insert_array.sv
module topk_insert_array #(
  parameter int K       = 100,
  parameter int SCORE_W = 16,
  parameter int ID_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      cand_valid,
  input  logic signed [SCORE_W-1:0] cand_score,
  input  logic [ID_W-1:0]           cand_id,
  output logic [K-1:0]              slot_valid,
  output logic signed [SCORE_W-1:0] slot_score [K],
  output logic [ID_W-1:0]           slot_id    [K]
);
  localparam logic signed [SCORE_W-1:0] MOST_NEG = {1'b1, {(SCORE_W-1){1'b0}}};

  logic [K-1:0] beats;

  for (genvar i = 0; i < K; i++) begin : g_slot
    // strict compare keeps earlier equal entries above later ones
    assign beats[i] = cand_valid && (!slot_valid[i] || (cand_score > slot_score[i]));

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        slot_valid[i] <= 1'b0;
        slot_score[i] <= MOST_NEG;
        slot_id[i]    <= '0;
      end else if (beats[i]) begin
        if (i > 0 && beats[(i > 0) ? i-1 : 0]) begin
          slot_valid[i] <= slot_valid[(i > 0) ? i-1 : 0];
          slot_score[i] <= slot_score[(i > 0) ? i-1 : 0];
          slot_id[i]    <= slot_id[(i > 0) ? i-1 : 0];
        end else begin
          slot_valid[i] <= 1'b1;
          slot_score[i] <= cand_score;
          slot_id[i]    <= cand_id;
        end
      end
    end
  end
endmodule

// File: rtl/topk_readout.sv
module topk_readout #(
  parameter int K       = 100,
  parameter int SCORE_W = 16,
  parameter int ID_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      go,
  input  logic [K-1:0]              slot_valid,
  input  logic signed [SCORE_W-1:0] slot_score [K],
  input  logic [ID_W-1:0]           slot_id    [K],
  output logic                      reading_o,
  output logic                      out_valid_o,
  output logic signed [SCORE_W-1:0] out_score_o,
  output logic [ID_W-1:0]           out_id_o,
  output logic                      out_last_o
);
  import topk_pkg::*;
  localparam int IW = (K > 1) ? $clog2(K) : 1;

  rd_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [K-1:0]  next_valid;
  logic          is_last;

  assign next_valid = slot_valid >> 1;
  assign is_last    = !next_valid[idx_q];
  assign reading_o  = (state_q == RD_RUN);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q     <= RD_IDLE;
      idx_q       <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_score_o <= '0;
      out_id_o    <= '0;
    end else if (state_q == RD_IDLE) begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      if (go) begin
        state_q <= RD_RUN;
        idx_q   <= '0;
      end
    end else if (slot_valid[idx_q]) begin
      out_valid_o <= 1'b1;
      out_last_o  <= is_last;
      out_score_o <= slot_score[idx_q];
      out_id_o    <= slot_id[idx_q];
      idx_q       <= idx_q + 1'b1;
      if (is_last) state_q <= RD_IDLE;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      state_q     <= RD_IDLE;
    end
  end
endmodule

// File: rtl/topk_selector.sv
module topk_selector #(
  parameter int LANES   = 16,
  parameter int K       = 100,
  parameter int SCORE_W = 16,
  parameter int ID_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      end_i,
  input  logic [LANES-1:0]          lane_valid_i,
  input  logic [LANES*SCORE_W-1:0]  lane_score_i,
  input  logic [LANES*ID_W-1:0]     lane_id_i,
  output logic [LANES-1:0]          lane_ready_o,
  output logic                      out_valid_o,
  output logic [SCORE_W-1:0]        out_score_o,
  output logic [ID_W-1:0]           out_id_o,
  output logic                      out_last_o
);
  logic                      reading;
  logic                      cand_valid;
  logic signed [SCORE_W-1:0] cand_score;
  logic [ID_W-1:0]           cand_id;
  logic [K-1:0]              slot_valid;
  logic signed [SCORE_W-1:0] slot_score [K];
  logic [ID_W-1:0]           slot_id    [K];
  logic signed [SCORE_W-1:0] rd_score;

  topk_rr_arbiter #(.LANES(LANES), .SCORE_W(SCORE_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst(rst), .clear(start_i),
    .enable(!reading && !end_i && !start_i),
    .valid_i(lane_valid_i), .score_i(lane_score_i), .id_i(lane_id_i),
    .grant_o(lane_ready_o),
    .cand_valid_o(cand_valid), .cand_score_o(cand_score), .cand_id_o(cand_id)
  );

  topk_insert_array #(.K(K), .SCORE_W(SCORE_W), .ID_W(ID_W)) u_arr (
    .clk(clk), .rst(rst), .clear(start_i),
    .cand_valid(cand_valid), .cand_score(cand_score), .cand_id(cand_id),
    .slot_valid(slot_valid), .slot_score(slot_score), .slot_id(slot_id)
  );

  topk_readout #(.K(K), .SCORE_W(SCORE_W), .ID_W(ID_W)) u_rd (
    .clk(clk), .rst(rst), .clear(start_i), .go(end_i),
    .slot_valid(slot_valid), .slot_score(slot_score), .slot_id(slot_id),
    .reading_o(reading), .out_valid_o(out_valid_o), .out_score_o(rd_score),
    .out_id_o(out_id_o), .out_last_o(out_last_o)
  );

  assign out_score_o = rd_score;
endmodule

// File: rtl/topk_selector_chk.sv
module topk_selector_chk #(
  parameter int LANES   = 16,
  parameter int SCORE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               end_i,
  input logic [LANES-1:0]   lane_valid_i,
  input logic [LANES-1:0]   lane_ready_o,
  input logic               out_valid_o,
  input logic [SCORE_W-1:0] out_score_o,
  input logic               out_last_o
);
  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_ready_o));

  // R3
  ready_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_ready_o & ~lane_valid_i) == '0);

  // R3
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i || end_i) |-> (lane_ready_o == '0));

  // R6
  descending_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && $past(out_valid_o) && !$past(out_last_o))
      |-> ($signed(out_score_o) <= $signed($past(out_score_o))));

  // R7
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last_o |-> out_valid_o);

  // R8
  start_silences_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !out_valid_o);
endmodule

bind topk_selector topk_selector_chk #(.LANES(LANES), .SCORE_W(SCORE_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .end_i(end_i),
  .lane_valid_i(lane_valid_i), .lane_ready_o(lane_ready_o),
  .out_valid_o(out_valid_o), .out_score_o(out_score_o), .out_last_o(out_last_o)
);

// File: tb/topk_selector_test.sv
module topk_selector_test;
  localparam int LANES = 4, K = 8, SW = 16, IW = 16, QD = 32;

  logic clk = 0, rst = 1, start_i = 0, end_i = 0;
  logic [LANES-1:0] lane_valid_i = '0;
  logic [LANES*SW-1:0] lane_score_i = '0;
  logic [LANES*IW-1:0] lane_id_i = '0;
  logic [LANES-1:0] lane_ready_o;
  logic out_valid_o, out_last_o;
  logic [SW-1:0] out_score_o;
  logic [IW-1:0] out_id_o;

  topk_selector #(.LANES(LANES), .K(K), .SCORE_W(SW), .ID_W(IW)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit wd_hit = 0;

  // row: {lane[3:0], score[15:0], id[15:0]}
  localparam int NV = 20;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0, 16'sd100, 16'h0100}, {4'd1, -16'sd5, 16'h0101}, {4'd2, 16'sd300, 16'h0102},
    {4'd3, 16'sd300, 16'h0103}, {4'd0, 16'sd42, 16'h0104}, {4'd1, 16'sd7, 16'h0105},
    {4'd2, 16'sd300, 16'h0106}, {4'd3, -16'sd200, 16'h0107}, {4'd0, 16'sd55, 16'h0108},
    {4'd1, 16'sd55, 16'h0109}, {4'd2, 16'sd1000, 16'h010A}, {4'd3, 16'sd12, 16'h010B},
    {4'd0, 16'h8000, 16'h010C}, {4'd1, 16'sd77, 16'h010D}, {4'd2, 16'sd300, 16'h010E},
    {4'd3, 16'sd6, 16'h010F}, {4'd0, 16'sd999, 16'h0110}, {4'd1, 16'sd55, 16'h0111},
    {4'd2, 16'sd0, 16'h0112}, {4'd3, -16'sd1, 16'h0113}};

  // reference model: stable descending list of the accepted candidates
  logic signed [SW-1:0] ref_s [K];
  logic [IW-1:0] ref_i [K];
  int ref_n = 0;

  logic signed [SW-1:0] q_s [LANES][QD];
  logic [IW-1:0] q_i [LANES][QD];
  int q_n [LANES];
  int q_h [LANES];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_clear();
    ref_n = 0;
    for (int l = 0; l < LANES; l++) begin q_n[l] = 0; q_h[l] = 0; end
  endtask

  task automatic ref_insert(input logic signed [SW-1:0] s, input logic [IW-1:0] id);
    int p;
    p = 0;
    while (p < ref_n && !(s > ref_s[p])) p++;
    if (p < K) begin
      for (int j = K-1; j > p; j--) begin ref_s[j] = ref_s[j-1]; ref_i[j] = ref_i[j-1]; end
      ref_s[p] = s; ref_i[p] = id;
      if (ref_n < K) ref_n++;
    end
  endtask

  task automatic enqueue(input int lane, input logic signed [SW-1:0] s, input logic [IW-1:0] id);
    q_s[lane][q_n[lane]] = s; q_i[lane][q_n[lane]] = id; q_n[lane]++;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    ref_clear();
  endtask

  task automatic feed();
    bit busy;
    int guard;
    busy = 1; guard = 0;
    while (busy && guard < 1000) begin
      guard++;
      @(negedge clk);
      busy = 0;
      for (int l = 0; l < LANES; l++) begin
        lane_valid_i[l] = (q_h[l] < q_n[l]);
        if (q_h[l] < q_n[l]) begin
          busy = 1;
          lane_score_i[l*SW +: SW] = q_s[l][q_h[l]];
          lane_id_i[l*IW +: IW] = q_i[l][q_h[l]];
        end
      end
      #1;
      for (int l = 0; l < LANES; l++)
        if (lane_ready_o[l] && lane_valid_i[l]) begin
          ref_insert(q_s[l][q_h[l]], q_i[l][q_h[l]]);
          q_h[l]++;
        end
    end
    @(negedge clk); lane_valid_i = '0;
  endtask

  // end pulse, then compare the readout against the model
  task automatic readout(input bit hold_lanes);
    int got; bit gap, lastseen;
    got = 0; gap = 0; lastseen = 0;
    @(negedge clk); end_i = 1;
    if (hold_lanes) lane_valid_i = '1;
    #1; if (hold_lanes) check(lane_ready_o == '0, "R3", "ready during end", lane_ready_o, 0);
    @(negedge clk); end_i = 0;
    for (int c = 0; c < K + 3; c++) begin
      @(negedge clk); #1;
      if (out_valid_o) begin
        if (gap || lastseen) check(0, "R6", "entry after gap or last", got, ref_n);
        if (got < K) begin
          check($signed(out_score_o) == ref_s[got], "R4", "score", $signed(out_score_o), ref_s[got]);
          check(out_id_o == ref_i[got], "R5", "identifier", out_id_o, ref_i[got]);
          check(out_last_o == (got == ref_n-1), "R7", "last flag", out_last_o, got == ref_n-1);
        end
        if (hold_lanes && !out_last_o)
          check(lane_ready_o == '0, "R3", "ready during readout", lane_ready_o, 0);
        if (out_last_o) lastseen = 1;
        got++;
      end else if (got > 0) gap = 1;
    end
    lane_valid_i = '0;
    check(got == ref_n, "R7", "entry count", got, ref_n);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    wd_hit = 1;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R9 reset state
    check(out_valid_o == 0 && out_last_o == 0, "R9", "outputs after reset", out_valid_o, 0);
    check(lane_ready_o == '0, "R9", "ready after reset", lane_ready_o, 0);
    readout(0);  // R9 empty array, R7 zero entries

    // table walk: R4 R5 R6 with more than K candidates and ties
    pulse_start();
    for (int v = 0; v < NV; v++)
      enqueue(int'(VEC[v][35:32]), VEC[v][31:16], VEC[v][15:0]);
    feed();
    readout(0);

    // fewer than K: R7
    pulse_start();
    enqueue(1, 16'sd20, 16'h0201); enqueue(1, 16'sd30, 16'h0202); enqueue(1, 16'sd20, 16'h0203);
    feed();
    readout(0);

    // zero candidates: R7
    pulse_start();
    readout(0);

    // start clears: R8
    pulse_start();
    for (int j = 0; j < 5; j++) enqueue(j % LANES, 16'(900 + j), 16'(16'h0300 + j));
    feed();
    pulse_start();
    enqueue(2, 16'sd3, 16'h0401); enqueue(3, 16'sd4, 16'h0402);
    feed();
    readout(0);

    // most negative score retained: R10
    pulse_start();
    enqueue(0, 16'h8000, 16'h0501);
    feed();
    check(ref_n == 1, "R10", "model count", ref_n, 1);
    readout(0);

    // discard below minimum of a full array, with lanes held valid in readout: R4 R3
    pulse_start();
    for (int j = 0; j < K; j++) enqueue(j % LANES, 16'(500 + j), 16'(16'h0600 + j));
    for (int j = 0; j < 4; j++) enqueue(j, 16'(100 + j), 16'(16'h0700 + j));
    enqueue(1, 16'sd500, 16'h07FF);  // equal to minimum: not retained
    feed();
    readout(1);

    // round-robin fairness and one grant per cycle: R1 R2
    pulse_start();
    begin
      int cnt [LANES];
      for (int l = 0; l < LANES; l++) cnt[l] = 0;
      for (int c = 0; c < 2*LANES; c++) begin
        @(negedge clk); lane_valid_i = '1; #1;
        check($countones(lane_ready_o) == 1, "R1", "grants per cycle", $countones(lane_ready_o), 1);
        for (int l = 0; l < LANES; l++) if (lane_ready_o[l]) cnt[l]++;
      end
      for (int l = 0; l < LANES; l++)
        check(cnt[l] == 2, "R2", "grants per lane", cnt[l], 2);
      @(negedge clk); lane_valid_i = '0;
    end
    // R8 start in the middle of a readout cancels it
    pulse_start();
    enqueue(0, 16'sd9, 16'h0801); enqueue(1, 16'sd8, 16'h0802);
    feed();
    @(negedge clk); end_i = 1;
    @(negedge clk); end_i = 0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0; #1;
    check(out_valid_o == 0, "R8", "valid after start", out_valid_o, 0);
    ref_clear();
    readout(0);

    if (!wd_hit) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule